// File: doc/BRIEF.md
# Warp Load Address Coalescer

This block sits between the load/store stage of a wide SIMT core and its memory port. It takes one warp-wide load request, which carries one address per lane and a mask of active lanes. It turns that request into the shortest list of aligned-segment memory transactions that serves every active lane. Lanes whose addresses share a segment are merged into one transaction. A scattered (gather) pattern becomes several transactions, sent one after another.

Each transaction carries the segment base address and a lane mask that tells the return path which lanes the segment serves. Transactions leave through a valid/ready handshake. A single-cycle done pulse marks the end of each request. A new request is taken only after the previous one has fully drained.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, req_ready_o is 1, txn_valid_o is 0 and done_o is 0.
- R2: A request whose 32 active lanes access consecutive 4-byte words inside one aligned 128-byte segment produces exactly one transaction, with all lane bits set.
- R3: Active lanes that fall in N distinct segments produce exactly N transactions, one at a time.
- R4: Inactive lanes (mask bit 0) never appear in a transaction mask, and their addresses never cause a transaction.
- R5: Each transaction is led by the lowest-numbered lane still pending. Its lane mask holds every pending lane in the leader's segment, so transactions come out in ascending order of leading lane.
- R6: txn_base_o is the leading lane's address with its low log2(128)=7 bits cleared.
- R7: A request with an all-zero mask produces no transaction. done_o pulses for one cycle in the cycle after acceptance.
- R8: req_ready_o stays 0 from the acceptance of a request that has active lanes until the cycle after its final transaction handshake. It is 1 otherwise.
- R9: done_o is 1 in exactly the cycle where the final transaction handshake (txn_valid_o and txn_ready_i both 1) completes, and in no other cycle of that request.
- R10: While txn_valid_o is 1 and txn_ready_i is 0, txn_valid_o, txn_base_o and txn_lanes_o hold their values into the next cycle.
- R11: The lane masks of one request's transactions are pairwise disjoint, and together they equal the active mask.
- R12: 32 consecutive words that start mid-segment (offset 64) produce two transactions: lanes 0-15 in the first, lanes 16-31 in the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Warp request present |
| req_ready_o | output | 1 | Block can take a request |
| req_addr_i | input | LANES*ADDR_W | Per-lane byte addresses, lane i in bits [i*ADDR_W +: ADDR_W] |
| req_mask_i | input | LANES | Active-lane mask, bit i for lane i |
| txn_valid_o | output | 1 | Transaction present |
| txn_ready_i | input | 1 | Memory side accepts the transaction |
| txn_base_o | output | ADDR_W | Aligned segment base address |
| txn_lanes_o | output | LANES | Lanes served by this transaction |
| done_o | output | 1 | Request finished (one-cycle pulse) |

## Verification
The bench builds the block with its defaults: 32 lanes, 32-bit addresses and 128-byte segments. With these values a full 32-way gather produces the longest transaction train, and a half-segment offset splits a contiguous warp across a segment boundary. Stalling the memory side on a fixed period exercises holding a pending transaction. Mixed lane-to-segment patterns check the lowest-lane-first order.

// File: rtl/coal_pkg.sv
`timescale 1ns/1ps
package coal_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } coal_state_e;
endpackage

// File: rtl/coal_pick.sv
`timescale 1ns/1ps
// Lowest set bit finder over the pending lanes.
module coal_pick #(
  parameter int LANES = 32,
  parameter int IDX_W = $clog2(LANES)
) (
  input  logic [LANES-1:0] pend,
  output logic [IDX_W-1:0] lead,
  output logic             any
);
  always_comb begin
    lead = '0;
    any  = |pend;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pend[i]) lead = IDX_W'(i);
    end
  end
endmodule

// File: rtl/coal_match.sv
`timescale 1ns/1ps
// Compares every lane's segment tag with the leader's tag.
module coal_match #(
  parameter int LANES   = 32,
  parameter int ADDR_W  = 32,
  parameter int SEG_LSB = 7,
  parameter int IDX_W   = $clog2(LANES)
) (
  input  logic [LANES-1:0][ADDR_W-1:0] addr,
  input  logic [LANES-1:0]             pend,
  input  logic [IDX_W-1:0]             lead,
  output logic [LANES-1:0]             hit,
  output logic [ADDR_W-1:0]            base
);
  localparam int TAG_W = ADDR_W - SEG_LSB;
  localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'((64'd1 << SEG_LSB) - 64'd1);

  logic [ADDR_W-1:0] lead_addr;
  logic [TAG_W-1:0]  lead_tag;

  assign lead_addr = addr[lead];
  assign lead_tag  = lead_addr[ADDR_W-1:SEG_LSB];
  assign base      = lead_addr & ~OFS_MASK;

  for (genvar g = 0; g < LANES; g++) begin : g_cmp
    assign hit[g] = pend[g] && (addr[g][ADDR_W-1:SEG_LSB] == lead_tag);
  end
endmodule

// File: rtl/warp_coalescer.sv
`timescale 1ns/1ps
module warp_coalescer #(
  parameter int LANES     = 32,
  parameter int ADDR_W    = 32,
  parameter int SEG_BYTES = 128
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic [LANES*ADDR_W-1:0] req_addr_i,
  input  logic [LANES-1:0]        req_mask_i,
  output logic                    txn_valid_o,
  input  logic                    txn_ready_i,
  output logic [ADDR_W-1:0]       txn_base_o,
  output logic [LANES-1:0]        txn_lanes_o,
  output logic                    done_o
);
  import coal_pkg::*;

  localparam int SEG_LSB = $clog2(SEG_BYTES);
  localparam int IDX_W   = $clog2(LANES);

  coal_state_e                 state_q;
  logic [LANES-1:0][ADDR_W-1:0] addr_q;
  logic [LANES-1:0]             pend_q;
  logic                         txn_valid_q;
  logic [ADDR_W-1:0]            txn_base_q;
  logic [LANES-1:0]             txn_lanes_q;
  logic                         last_q;
  logic                         empty_q;

  logic [IDX_W-1:0]  lead;
  logic              pend_any;
  logic [LANES-1:0]  hit;
  logic [ADDR_W-1:0] seg_base;
  logic              slot_free;
  logic              txn_fire;
  logic [LANES-1:0]  pend_next;

  coal_pick #(.LANES(LANES), .IDX_W(IDX_W)) u_pick (
    .pend (pend_q),
    .lead (lead),
    .any  (pend_any)
  );

  coal_match #(.LANES(LANES), .ADDR_W(ADDR_W), .SEG_LSB(SEG_LSB), .IDX_W(IDX_W)) u_match (
    .addr (addr_q),
    .pend (pend_q),
    .lead (lead),
    .hit  (hit),
    .base (seg_base)
  );

  assign txn_fire  = txn_valid_q && txn_ready_i;
  assign slot_free = !txn_valid_q || txn_ready_i;
  assign pend_next = pend_q & ~hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      pend_q      <= '0;
      txn_valid_q <= 1'b0;
      txn_base_q  <= '0;
      txn_lanes_q <= '0;
      last_q      <= 1'b0;
      empty_q     <= 1'b0;
    end else begin
      empty_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            addr_q <= req_addr_i;
            pend_q <= req_mask_i;
            if (req_mask_i == '0) empty_q <= 1'b1;
            else                  state_q <= ST_BUSY;
          end
        end
        default: begin
          if (slot_free) begin
            if (pend_any) begin
              txn_valid_q <= 1'b1;
              txn_base_q  <= seg_base;
              txn_lanes_q <= hit;
              last_q      <= (pend_next == '0);
              pend_q      <= pend_next;
            end else begin
              txn_valid_q <= 1'b0;
            end
            if (txn_fire && last_q) state_q <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign txn_valid_o = txn_valid_q;
  assign txn_base_o  = txn_base_q;
  assign txn_lanes_o = txn_lanes_q;
  assign done_o      = (txn_fire && last_q) || empty_q;
endmodule

// File: rtl/coal_chk.sv
`timescale 1ns/1ps
module coal_chk #(
  parameter int LANES     = 32,
  parameter int ADDR_W    = 32,
  parameter int SEG_BYTES = 128
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    req_valid_i,
  input logic                    req_ready_o,
  input logic [LANES*ADDR_W-1:0] req_addr_i,
  input logic [LANES-1:0]        req_mask_i,
  input logic                    txn_valid_o,
  input logic                    txn_ready_i,
  input logic [ADDR_W-1:0]       txn_base_o,
  input logic [LANES-1:0]        txn_lanes_o,
  input logic                    done_o
);
  localparam int SEG_LSB = $clog2(SEG_BYTES);

  logic [LANES-1:0] mask_q;
  logic [LANES-1:0] served_q;
  logic [ADDR_W-1:0] addr_seen;

  assign addr_seen = req_addr_i[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q   <= '0;
      served_q <= '0;
    end else if (req_valid_i && req_ready_o) begin
      mask_q   <= req_mask_i;
      served_q <= '0;
    end else if (txn_valid_o && txn_ready_i) begin
      served_q <= served_q | txn_lanes_o;
    end
  end

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (txn_valid_o && !txn_ready_i) |=> (txn_valid_o && $stable(txn_base_o) && $stable(txn_lanes_o)));

  // R8
  busy_chk: assert property (@(posedge clk) disable iff (rst)
    txn_valid_o |-> !req_ready_o);

  // R4
  inactive_chk: assert property (@(posedge clk) disable iff (rst)
    txn_valid_o |-> ((txn_lanes_o & ~mask_q) == '0));

  // R11
  disjoint_chk: assert property (@(posedge clk) disable iff (rst)
    txn_valid_o |-> ((txn_lanes_o & served_q) == '0));

  // R6
  align_chk: assert property (@(posedge clk) disable iff (rst)
    txn_valid_o |-> (txn_base_o[SEG_LSB-1:0] == '0));

  // R5
  nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    txn_valid_o |-> (txn_lanes_o != '0));

  // R9
  done_fire_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && txn_valid_o) |-> txn_ready_i);

  // R8
  done_ready_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> req_ready_o);

  // R11
  cover_all_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && txn_valid_o) |-> ((served_q | txn_lanes_o) == mask_q));

  // R1
  always_comb begin
    if (!rst && req_ready_o && addr_seen !== 'x) begin
      reset_idle_chk: assert (!(txn_valid_o && req_ready_o));
    end
  end
endmodule

bind warp_coalescer coal_chk #(
  .LANES(LANES), .ADDR_W(ADDR_W), .SEG_BYTES(SEG_BYTES)
) u_chk (.*);

// File: tb/sim_warp_coalescer.sv
`timescale 1ns/1ps
module sim_warp_coalescer;
  localparam int LANES  = 32;
  localparam int ADDR_W = 32;
  localparam int SEGB   = 128;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic                    req_valid = 1'b0;
  logic                    req_ready;
  logic [LANES*ADDR_W-1:0] req_addr = '0;
  logic [LANES-1:0]        req_mask = '0;
  logic                    txn_valid;
  logic                    txn_ready = 1'b0;
  logic [ADDR_W-1:0]       txn_base;
  logic [LANES-1:0]        txn_lanes;
  logic                    done;

  warp_coalescer #(.LANES(LANES), .ADDR_W(ADDR_W), .SEG_BYTES(SEGB)) u0 (
    .clk(clk), .rst(rst),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_mask_i(req_mask),
    .txn_valid_o(txn_valid), .txn_ready_i(txn_ready),
    .txn_base_o(txn_base), .txn_lanes_o(txn_lanes),
    .done_o(done)
  );

  always #10 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  int last_got;
  logic [ADDR_W-1:0] a [LANES];
  logic [ADDR_W-1:0] exp_base  [LANES];
  logic [LANES-1:0]  exp_lanes [LANES];

  task automatic chk(input string rq, input logic ok, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // Drives one request from a[] and m, then follows every transaction.
  task automatic run_req(input logic [LANES-1:0] m, input int stall);
    logic [LANES-1:0] pend;
    logic [LANES-1:0] lanes;
    logic [ADDR_W-1:0] hb;
    logic [LANES-1:0] hl;
    int n_exp, got, cyc, ld;
    logic held;
    pend = m;
    n_exp = 0;
    while (pend != '0) begin
      ld = 0;
      for (int i = LANES - 1; i >= 0; i--) if (pend[i]) ld = i;
      lanes = '0;
      for (int i = 0; i < LANES; i++)
        if (pend[i] && ((a[i] >> 7) == (a[ld] >> 7))) lanes[i] = 1'b1;
      exp_base[n_exp]  = (a[ld] >> 7) << 7;
      exp_lanes[n_exp] = lanes;
      pend &= ~lanes;
      n_exp++;
    end

    @(negedge clk);
    chk("R8", req_ready == 1'b1, "ready before request", 64'(req_ready), 64'd1);
    for (int i = 0; i < LANES; i++) req_addr[i*ADDR_W +: ADDR_W] = a[i];
    req_mask  = m;
    req_valid = 1'b1;
    txn_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;

    if (n_exp == 0) begin
      chk("R7", done == 1'b1, "done after empty request", 64'(done), 64'd1);
      chk("R7", txn_valid == 1'b0, "no txn for empty request", 64'(txn_valid), 64'd0);
      @(negedge clk);
      chk("R7", done == 1'b0, "done is one cycle", 64'(done), 64'd0);
      chk("R7", txn_valid == 1'b0, "still no txn", 64'(txn_valid), 64'd0);
      last_got = 0;
      return;
    end

    chk("R8", req_ready == 1'b0, "busy after accept", 64'(req_ready), 64'd0);
    got = 0; cyc = 0; held = 1'b0; hb = '0; hl = '0;
    while (got < n_exp && cyc < 400) begin
      txn_ready = (stall == 0) || ((cyc % stall) != 0);
      #1;
      if (txn_valid) begin
        if (held) begin
          chk("R10", txn_base == hb, "base held under stall", 64'(txn_base), 64'(hb));
          chk("R10", txn_lanes == hl, "lanes held under stall", 64'(txn_lanes), 64'(hl));
        end
        chk("R8", req_ready == 1'b0, "busy while txn pending", 64'(req_ready), 64'd0);
        if (txn_ready) begin
          chk("R6", txn_base == exp_base[got], "segment base", 64'(txn_base), 64'(exp_base[got]));
          chk("R5", txn_lanes == exp_lanes[got], "lane mask", 64'(txn_lanes), 64'(exp_lanes[got]));
          chk("R9", done == (got == n_exp - 1), "done on final handshake only",
              64'(done), 64'(got == n_exp - 1));
          got++;
          held = 1'b0;
        end else begin
          chk("R9", done == 1'b0, "no done while stalled", 64'(done), 64'd0);
          held = 1'b1; hb = txn_base; hl = txn_lanes;
        end
      end else begin
        chk("R9", done == 1'b0, "no done without txn", 64'(done), 64'd0);
      end
      @(negedge clk);
      cyc++;
    end
    txn_ready = 1'b0;
    chk("R3", got == n_exp, "transaction count", 64'(got), 64'(n_exp));
    chk("R8", req_ready == 1'b1, "ready after final handshake", 64'(req_ready), 64'd1);
    chk("R11", txn_valid == 1'b0, "no extra txn", 64'(txn_valid), 64'd0);
    last_got = got;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", req_ready == 1'b1, "reset ready", 64'(req_ready), 64'd1);
    chk("R1", txn_valid == 1'b0, "reset valid", 64'(txn_valid), 64'd0);
    chk("R1", done == 1'b0, "reset done", 64'(done), 64'd0);
    rst = 1'b0;
  endtask

  task automatic t_contig();
    for (int i = 0; i < LANES; i++) a[i] = 32'h0000_1000 + 32'(4 * i);
    run_req('1, 0);
    chk("R2", last_got == 1, "contiguous warp merges", 64'(last_got), 64'd1);
  endtask

  task automatic t_unaligned();
    for (int i = 0; i < LANES; i++) a[i] = 32'h0000_2040 + 32'(4 * i);
    run_req('1, 0);
    chk("R12", last_got == 2, "mid-segment start splits in two", 64'(last_got), 64'd2);
  endtask

  task automatic t_gather(input int stall);
    for (int i = 0; i < LANES; i++) a[i] = 32'h0001_0000 + 32'(i * 256) + 32'(4 * (i % 8));
    run_req('1, stall);
    chk("R3", last_got == LANES, "full gather count", 64'(last_got), 64'(LANES));
  endtask

  task automatic t_partial();
    for (int i = 0; i < LANES; i++)
      a[i] = ((32'h0F0F_00F0 >> i) & 1) ? 32'h0000_3000 + 32'(4 * i) : 32'h0090_0000 + 32'(i * 512);
    run_req(32'h0F0F_00F0, 0);
    chk("R4", last_got == 1, "inactive lanes add no traffic", 64'(last_got), 64'd1);
  endtask

  task automatic t_order();
    for (int i = 0; i < LANES; i++)
      a[i] = (i % 3 == 0) ? 32'h0000_5000 + 32'(4 * i) :
             (i % 3 == 1) ? 32'h0000_1000 + 32'(4 * i) : 32'h0000_3000 + 32'(4 * i);
    run_req(32'hFFFF_FFFE, 0);
    chk("R5", last_got == 3, "three segments by lowest lane", 64'(last_got), 64'd3);
  endtask

  task automatic t_empty();
    for (int i = 0; i < LANES; i++) a[i] = 32'(i * 4096);
    run_req('0, 0);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_contig();
    t_unaligned();
    t_gather(0);
    t_partial();
    t_order();
    t_empty();
    t_gather(3);
    t_contig();
    summary();
    $finish;
  end
endmodule